// File: doc/BRIEF.md
# PDM In-Band Command Detector

This block sits on the receive side of a stereo pulse-density-modulated link. Two channels share one data line: one is valid at the rising edge of the bit clock and the other at the falling edge. A static select input chooses which of the two the block listens to. Both the bit clock and the data line are brought into the fast core clock through two-flop synchronizers. The chosen channel's bits are passed on as a one-bit audio stream with a one-cycle valid strobe.

The same bit stream also carries commands. A command is one 8-bit word, sent most significant bit first, that repeats back to back. The detector tracks the last eight bits. It reports a command once the word has occurred 128 times in an unbroken run, and it does this at whatever bit offset the run starts. Three words are recognised. The standby word 0xAC suspends the audio strobe. Two further words, set by parameter, select two other operating modes. Standby ends by itself after 1024 consecutive bits in which the standby word is not being tracked.

Top module: `pdm_ctrl_detect`

## Requirements
- R1: During and directly after reset, `mode` is 0 (active), and `modeChange` and `audioValid` are low.
- R2: With `chanSel` low, the block uses the bit present at the rising `pdmClk` edge. With `chanSel` high, it uses the bit present at the falling edge. Bits of the other channel have no effect on the audio output or on `mode`.
- R3: Outside standby, every selected bit appears on `audioBit`, in order, together with a one-cycle `audioValid` pulse.
- R4: `mode` codes are 0 active, 1 standby, 2 word A (default 0xF0) and 3 word B (default 0xCC). Words are received MSB first. A run of word B moves `mode` to 3.
- R5: A word is accepted on the bit that completes its 128th consecutive occurrence, which is the 1024th bit of the run. `mode` and `modeChange` update on that bit.
- R6: A run of 127 occurrences that ends in a mismatching bit causes no mode change.
- R7: A run that starts part way into a word (any rotation of it) is accepted as that word.
- R8: Acceptance of 0xAC sets `mode` to 1. While `mode` is 1, `audioValid` stays low.
- R9: `modeChange` pulses only when the value of `mode` changes. Further repetitions after an acceptance produce no new pulse.
- R10: In standby, 1024 consecutive selected bits during which the standby word is not being tracked return `mode` to 0. Tracking the standby word again restarts that count.
- R11: If a command acceptance and the standby exit fall on the same bit, the accepted command sets `mode`.
- R12: `modeChange` is a one-cycle pulse, raised exactly in the cycle that `mode` takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| pdmClk | input | 1 | PDM bit clock (asynchronous to clk) |
| pdmData | input | 1 | Shared two-channel PDM data line |
| chanSel | input | 1 | Static channel select: 0 rising-edge channel, 1 falling-edge channel |
| audioBit | output | 1 | Last selected bit |
| audioValid | output | 1 | One-cycle strobe for a new `audioBit` outside standby |
| mode | output | 2 | Current mode code (see R4) |
| modeChange | output | 1 | One-cycle pulse when `mode` changes |

## Verification
Two events can fall on the same selected bit: the standby-exit count expiring and a new command word being accepted. The bench sends word A directly after a standby run of 0xAC. Word A's first bit happens to agree with the next expected 0xAC bit, so the break occurs on its second bit. From that bit on, both the exit count and word A's occurrence count run in lockstep and complete on the same bit. The scoreboard expects exactly one `modeChange`, on that bit, with `mode` equal to 2. This also shows that the rotated candidate was recognised.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int PCD_WORD_W = 8;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_CMDA    = 2'd2,
    MODE_CMDB    = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;    // current bit broke the run: it becomes bit 0 of a new fill
    logic loadCand;   // current bit completes a fill: capture the candidate word
    logic passAudio;  // audio strobe enabled
  } ctrl_s;

  // true when w equals some rotation of r
  function automatic logic isRot(input logic [PCD_WORD_W-1:0] w,
                                 input logic [PCD_WORD_W-1:0] r);
    logic [2*PCD_WORD_W-1:0] d;
    logic hit;
    d   = {r, r};
    hit = 1'b0;
    for (int k = 0; k < PCD_WORD_W; k++) begin
      if (d[k +: PCD_WORD_W] == w) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pdmClk,
  input  logic                  pdmData,
  input  logic                  chanSel,
  input  ctrl_s                 ctrl,
  output logic                  bitStb,
  output logic                  bitVal,
  output logic                  bitHit,
  output logic                  wordEnd,
  output logic [PCD_WORD_W-1:0] candWord,
  output logic [PCD_WORD_W-1:0] fillWord,
  output logic                  audioBit,
  output logic                  audioValid
);

  localparam int POS_W = $clog2(PCD_WORD_W);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(PCD_WORD_W - 1);

  logic [1:0] clkSync, datSync;
  logic       clkPrev;
  logic [PCD_WORD_W-1:0] shReg, candReg;
  logic [POS_W-1:0]      bitPos;

  // two-flop synchronizers and edge pick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '0;
      datSync <= '0;
      clkPrev <= 1'b0;
      bitStb  <= 1'b0;
      bitVal  <= 1'b0;
    end else begin
      clkSync <= {clkSync[0], pdmClk};
      datSync <= {datSync[0], pdmData};
      clkPrev <= clkSync[1];
      bitStb  <= chanSel ? (clkPrev & ~clkSync[1]) : (~clkPrev & clkSync[1]);
      bitVal  <= datSync[1];
    end
  end

  assign fillWord = {shReg[PCD_WORD_W-2:0], bitVal};
  assign candWord = candReg;
  assign wordEnd  = (bitPos == POS_MAX);
  assign bitHit   = (bitVal == candReg[POS_MAX - bitPos]);

  // shift register, candidate and bit position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      candReg <= '0;
      bitPos  <= '0;
    end else if (bitStb) begin
      shReg  <= fillWord;
      bitPos <= ctrl.restart ? POS_W'(1) : bitPos + 1'b1;
      if (ctrl.restart)       candReg <= '0;
      else if (ctrl.loadCand) candReg <= fillWord;
    end
  end

  // audio output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      audioBit   <= 1'b0;
      audioValid <= 1'b0;
    end else begin
      audioValid <= bitStb & ctrl.passAudio;
      if (bitStb) audioBit <= bitVal;
    end
  end

  // R3
  audio_from_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    audioValid |-> $past(bitStb));

endmodule

// File: rtl/pcd_control.sv
module pcd_control
  import pcd_pkg::*;
#(
  parameter int                    REPS      = 128,
  parameter int                    EXIT_BITS = 1024,
  parameter logic [PCD_WORD_W-1:0] STBY_WORD = 8'hAC,
  parameter logic [PCD_WORD_W-1:0] CMDA_WORD = 8'hF0,
  parameter logic [PCD_WORD_W-1:0] CMDB_WORD = 8'hCC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitStb,
  input  logic                  bitHit,
  input  logic                  wordEnd,
  input  logic [PCD_WORD_W-1:0] candWord,
  input  logic [PCD_WORD_W-1:0] fillWord,
  output ctrl_s                 ctrl,
  output mode_e                 modeQ,
  output logic                  modeChange
);

  localparam int REP_W  = $clog2(REPS);
  localparam int EXIT_W = $clog2(EXIT_BITS + 1);

  logic              haveCand, fired;
  logic [REP_W-1:0]  repCnt;
  logic [EXIT_W-1:0] exitCnt, exitNext;
  logic              accept, hasMode, trackNext, exitFire;
  mode_e             wordMode, modeNext;

  always_comb begin
    ctrl.restart   = bitStb & haveCand & ~bitHit;
    ctrl.loadCand  = bitStb & ~haveCand & wordEnd;
    ctrl.passAudio = (modeQ != MODE_STANDBY);
  end

  assign accept = bitStb & haveCand & bitHit & wordEnd & ~fired &
                  (repCnt == REP_W'(REPS - 1));

  // classify the candidate at any alignment
  always_comb begin
    hasMode  = 1'b1;
    wordMode = MODE_ACTIVE;
    if (isRot(candWord, STBY_WORD))      wordMode = MODE_STANDBY;
    else if (isRot(candWord, CMDA_WORD)) wordMode = MODE_CMDA;
    else if (isRot(candWord, CMDB_WORD)) wordMode = MODE_CMDB;
    else                                 hasMode  = 1'b0;
  end

  // standby word tracked after this bit
  always_comb begin
    if (ctrl.restart)       trackNext = 1'b0;
    else if (ctrl.loadCand) trackNext = isRot(fillWord, STBY_WORD);
    else                    trackNext = haveCand & isRot(candWord, STBY_WORD);
  end

  assign exitNext = exitCnt + 1'b1;
  assign exitFire = bitStb & (modeQ == MODE_STANDBY) & ~trackNext &
                    (exitNext == EXIT_W'(EXIT_BITS));

  // command acceptance has priority over the standby exit
  always_comb begin
    if (accept && hasMode) modeNext = wordMode;
    else if (exitFire)     modeNext = MODE_ACTIVE;
    else                   modeNext = modeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveCand <= 1'b0;
      fired    <= 1'b0;
      repCnt   <= '0;
    end else if (bitStb) begin
      if (!haveCand) begin
        if (wordEnd) begin
          haveCand <= 1'b1;
          repCnt   <= REP_W'(1);
        end
      end else if (!bitHit) begin
        haveCand <= 1'b0;
        fired    <= 1'b0;
        repCnt   <= '0;
      end else if (wordEnd && !fired) begin
        if (accept) fired  <= 1'b1;
        else        repCnt <= repCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= MODE_ACTIVE;
      modeChange <= 1'b0;
      exitCnt    <= '0;
    end else begin
      modeQ      <= modeNext;
      modeChange <= (modeNext != modeQ);
      if (modeQ != MODE_STANDBY || modeNext != modeQ) exitCnt <= '0;
      else if (bitStb) exitCnt <= trackNext ? '0 : exitNext;
    end
  end

  // R12
  change_has_new_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |-> (modeQ != $past(modeQ)));
  // R9
  mode_move_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != $past(modeQ)) |-> modeChange);
  // R5
  change_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |-> $past(bitStb));
  // R10
  exit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    exitCnt < EXIT_W'(EXIT_BITS));

endmodule

// File: rtl/pdm_ctrl_detect.sv
module pdm_ctrl_detect
  import pcd_pkg::*;
#(
  parameter int                    REPS      = 128,
  parameter int                    EXIT_BITS = 1024,
  parameter logic [PCD_WORD_W-1:0] STBY_WORD = 8'hAC,
  parameter logic [PCD_WORD_W-1:0] CMDA_WORD = 8'hF0,
  parameter logic [PCD_WORD_W-1:0] CMDB_WORD = 8'hCC
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdmClk,
  input  logic       pdmData,
  input  logic       chanSel,
  output logic       audioBit,
  output logic       audioValid,
  output logic [1:0] mode,
  output logic       modeChange
);

  ctrl_s ctrl;
  mode_e modeQ;
  logic  bitStb, bitVal, bitHit, wordEnd;
  logic [PCD_WORD_W-1:0] candWord, fillWord;

  pcd_datapath i_dp (
    .clk(clk), .rstN(rstN), .pdmClk(pdmClk), .pdmData(pdmData), .chanSel(chanSel),
    .ctrl(ctrl), .bitStb(bitStb), .bitVal(bitVal), .bitHit(bitHit), .wordEnd(wordEnd),
    .candWord(candWord), .fillWord(fillWord), .audioBit(audioBit), .audioValid(audioValid)
  );

  pcd_control #(
    .REPS(REPS), .EXIT_BITS(EXIT_BITS),
    .STBY_WORD(STBY_WORD), .CMDA_WORD(CMDA_WORD), .CMDB_WORD(CMDB_WORD)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .bitHit(bitHit), .wordEnd(wordEnd),
    .candWord(candWord), .fillWord(fillWord), .ctrl(ctrl), .modeQ(modeQ),
    .modeChange(modeChange)
  );

  assign mode = modeQ;

  // R8
  quiet_in_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    audioValid |-> ($past(mode) != 2'd1));

endmodule

// File: tb/test_pdm_ctrl_detect.sv
`timescale 1ns/1ps
module test_pdm_ctrl_detect;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdmClk = 1'b0;
  logic pdmData = 1'b0;
  logic chanSel = 1'b0;
  logic audioBit, audioValid, modeChange;
  logic [1:0] mode;

  always #2.5 clk = ~clk;

  pdm_ctrl_detect i_pdm_ctrl_detect (
    .clk(clk), .rstN(rstN), .pdmClk(pdmClk), .pdmData(pdmData), .chanSel(chanSel),
    .audioBit(audioBit), .audioValid(audioValid), .mode(mode), .modeChange(modeChange)
  );

  typedef struct {
    logic [1:0] m;
    int         idx;
    string      req;
  } ev_t;

  ev_t  expQ[$];
  bit   audQ[$];
  int   checks = 0, fails = 0, selCnt = 0, stbyValid = 0, validCnt = 0;
  bit   audioCheck = 0, inStby = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic expectEv(input logic [1:0] m, input int idx, input string req);
    ev_t e;
    e.m = m; e.idx = idx; e.req = req;
    expQ.push_back(e);
  endtask

  // one bit period: rising-edge channel l, falling-edge channel r (12 core cycles)
  task automatic pairBit(input bit l, input bit r);
    @(negedge clk) pdmData = l;
    repeat (3) @(negedge clk);
    pdmClk = 1'b1;
    if (!chanSel) begin selCnt++; if (audioCheck) audQ.push_back(l); end
    repeat (3) @(negedge clk);
    pdmData = r;
    repeat (3) @(negedge clk);
    pdmClk = 1'b0;
    if (chanSel) begin selCnt++; if (audioCheck) audQ.push_back(r); end
    repeat (2) @(negedge clk);
  endtask

  task automatic sendSel(input bit b, input bit o);
    if (chanSel) pairBit(o, b);
    else         pairBit(b, o);
  endtask

  task automatic sendWords(input logic [7:0] w, input logic [7:0] o, input int n);
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) sendSel(w[k], o[k]);
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendSel(1'b0, 1'b1);
  endtask

  task automatic sendAudio(input int n);
    logic [7:0] lf = 8'h5B;
    audioCheck = 1;
    for (int i = 0; i < n; i++) begin
      sendSel(lf[0], ~lf[0]);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    repeat (10) @(negedge clk);
    audioCheck = 0;
    chk(audQ.size() == 0, "R3", "audio bits not delivered", audQ.size(), 0);
    audQ.delete();
  endtask

  task automatic doReset(input bit sel);
    rstN = 1'b0; chanSel = sel; pdmClk = 1'b0; pdmData = 1'b0;
    inStby = 0; selCnt = 0;
    repeat (6) @(negedge clk);
    chk(mode == 2'd0, "R1", "mode in reset", mode, 0);
    chk(modeChange == 1'b0 && audioValid == 1'b0, "R1", "strobes in reset",
        {modeChange, audioValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(mode == 2'd0 && !modeChange && !audioValid, "R1", "state after reset",
        mode, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (audioValid) validCnt++;
      if (audioValid && inStby) stbyValid++;
      if (audioValid && audioCheck && audQ.size() > 0) begin
        bit e;
        e = audQ.pop_front();
        chk(audioBit == e, chanSel ? "R2 R3" : "R3", "audio bit", audioBit, e);
      end
      if (modeChange) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected mode change", mode, -1);
        end else begin
          ev_t e;
          e = expQ.pop_front();
          chk(mode == e.m, e.req, "mode after change", mode, e.m);
          chk(selCnt == e.idx, e.req, "bit index of change", selCnt, e.idx);
        end
        inStby = (mode == 2'd1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int v0;
    doReset(1'b0);
    sendAudio(64);
    sendZeros(16);

    // R6: 127 occurrences then a break
    sendWords(8'hAC, 8'h00, 127);
    sendZeros(16);
    chk(mode == 2'd0 && expQ.size() == 0, "R6", "mode after 127 words", mode, 0);

    // R5 / R8: standby on the 1024th bit
    expectEv(2'd1, selCnt + 1024, "R5 R8");
    sendWords(8'hAC, 8'h00, 128);
    // R9: further repetitions give no pulse
    sendWords(8'hAC, 8'h00, 10);
    chk(mode == 2'd1 && expQ.size() == 0, "R9", "mode after extra words", mode, 1);

    // R10: tracking the standby word again restarts the exit count
    sendZeros(200);
    sendWords(8'hAC, 8'h00, 3);
    chk(mode == 2'd1, "R10", "still standby after short break", mode, 1);
    expectEv(2'd0, selCnt + 1024, "R10");
    sendZeros(1024);
    repeat (10) @(negedge clk);
    chk(mode == 2'd0, "R10", "active after exit", mode, 0);
    chk(stbyValid == 0, "R8", "audio strobes in standby", stbyValid, 0);

    // R11 / R7: command and exit complete on the same bit, rotated run
    expectEv(2'd1, selCnt + 1024, "R5");
    sendWords(8'hAC, 8'h00, 128);
    expectEv(2'd2, selCnt + 1025, "R7 R11");
    sendWords(8'hF0, 8'h00, 129);
    chk(stbyValid == 0, "R8", "audio strobes in standby", stbyValid, 0);
    v0 = validCnt;
    sendZeros(16);
    chk(validCnt - v0 == 16, "R3", "audio strobes after standby", validCnt - v0, 16);

    // R4: word B
    expectEv(2'd3, selCnt + 1024, "R4");
    sendWords(8'hCC, 8'h00, 128);
    repeat (10) @(negedge clk);
    chk(mode == 2'd3, "R4", "mode for word B", mode, 3);

    // R2: falling-edge channel, other channel carries word B
    doReset(1'b1);
    sendAudio(32);
    sendZeros(16);
    expectEv(2'd2, selCnt + 1024, "R2");
    sendWords(8'hF0, 8'hCC, 128);
    repeat (20) @(negedge clk);
    chk(mode == 2'd2, "R2", "mode from selected channel", mode, 2);
    chk(expQ.size() == 0, "R5", "missing mode changes", expQ.size(), 0);
    finishRun();
  end

endmodule